// File: doc/BRIEF.md
# Parallel Port Floppy Pin Sharing Multiplexer

This block lets a floppy disk controller borrow the pins of a parallel port. A two-bit mode register picks plain parallel port operation or one of two floppy modes. In the first floppy mode only drive 1 is brought out on the port pins. In the second floppy mode drives 0 and 1 are both brought out. While a floppy mode is active, the parallel port engine loses the pins. Host reads of the port's data, control and status registers then return fixed values that look like an unplugged cable, except for data reads, which echo the last byte written.

The floppy outputs are driven onto the pins only when the drive select register points at a drive that the current mode routes to the port. Otherwise the pins float. In normal mode every pin, enable and read path passes straight through from the parallel port engine.

Top module: `ppfd_pin_mux`

## Requirements
- R1: After reset the mode is normal (00) and the echoed data byte is 8'h00.
- R2: A mode write with `mode_wr_i` takes effect on the next clock edge. The encodings are 00 normal, 01 floppy mode 1, 10 floppy mode 2, and 11 behaves as normal.
- R3: In normal mode, `pd_o` equals `pp_pd_i`, `ctl_o` equals `pp_ctl_i`, every `pd_oe_o` bit equals `pp_pd_oe_i`, and every `ctl_oe_o` bit equals `pp_ctl_oe_i`.
- R4: `rd_data_o` equals `pp_rd_data_i` in normal mode for every `rd_sel_i`. It does the same in any mode when `rd_sel_i` is 11.
- R5: Each `data_wr_i` captures `data_wdata_i` on the next edge, in any mode. In a floppy mode, a read with `rd_sel_i` = 00 (data) returns the captured byte.
- R6: In a floppy mode, a read with `rd_sel_i` = 10 (control) returns 8'h04. The bits are strobe (bit 0), autofeed (bit 1) and select-in (bit 3) all 0, with init (bit 2) 1 and bits 7:4 0.
- R7: In a floppy mode, a read with `rd_sel_i` = 01 (status) returns 8'h48. The bits are busy_n (bit 7), paper end (bit 5) and select (bit 4) all 0, with ack_n (bit 6) and error_n (bit 3) 1 and bits 2:0 0.
- R8: In a floppy mode, `pd_o` = {ds1, ds0, step, dir, wgate, hdsel, densel, wdata} taken from the floppy inputs, with bit 0 = wdata. `ctl_o` = {0, 0, mtr1, mtr0}.
- R9: In mode 1, the pins are enabled only while `drv_sel_i` = 1. Then `pd_oe_o` = 8'hBF and `ctl_oe_o` = 4'b0010, so the drive 0 select and motor pins stay off. Otherwise all enables are 0.
- R10: In mode 2, the pins are enabled while `drv_sel_i` is 0 or 1, with `pd_oe_o` = 8'hFF and `ctl_oe_o` = 4'b0011. For `drv_sel_i` of 2 or 3 all enables are 0.
- R11: In a floppy mode, `pp_pd_i`, `pp_pd_oe_i`, `pp_ctl_i`, `pp_ctl_oe_i` and `pp_rd_data_i` (for reads with `rd_sel_i` other than 11) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 2 | New mode value |
| data_wr_i | input | 1 | Host write to the port data register |
| data_wdata_i | input | 8 | Byte written to the data register |
| rd_sel_i | input | 2 | Register being read: 00 data, 01 status, 10 control, 11 other |
| pp_rd_data_i | input | 8 | Live read value from the parallel port engine |
| rd_data_o | output | 8 | Read value returned to the host |
| pp_pd_i | input | 8 | Parallel engine data pin values |
| pp_pd_oe_i | input | 1 | Parallel engine data pin enable |
| pp_ctl_i | input | 4 | Parallel engine control pin values |
| pp_ctl_oe_i | input | 1 | Parallel engine control pin enable |
| fdc_wdata_i | input | 1 | Floppy write data |
| fdc_densel_i | input | 1 | Floppy density select |
| fdc_hdsel_i | input | 1 | Floppy head select |
| fdc_wgate_i | input | 1 | Floppy write gate |
| fdc_dir_i | input | 1 | Floppy step direction |
| fdc_step_i | input | 1 | Floppy step pulse |
| fdc_ds_i | input | 2 | Floppy drive selects, bit n for drive n |
| fdc_mtr_i | input | 2 | Floppy motor enables, bit n for drive n |
| drv_sel_i | input | 2 | Drive number from the drive select register |
| pd_o | output | 8 | Data pin output values |
| pd_oe_o | output | 8 | Data pin output enables |
| ctl_o | output | 4 | Control pin output values |
| ctl_oe_o | output | 4 | Control pin output enables |

## Verification
The assertions assume that `drv_sel_i` and `rd_sel_i` are stable and known around each clock edge. They also assume that a mode write and a data write arriving in the same cycle are independent events. The bench changes every input only just after a rising edge and samples just before the next one. It walks all four mode encodings, changing the mode mid-run. Within each mode it sweeps `drv_sel_i` and `rd_sel_i` over all values while randomising the parallel engine and floppy inputs.

// File: rtl/ppfd_pkg.sv
package ppfd_pkg;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int MW = 2;

  typedef enum logic [MW-1:0] {
    PM_NORMAL = 2'b00,
    PM_ONE    = 2'b01,
    PM_TWO    = 2'b10,
    PM_RSVD   = 2'b11
  } pmode_e;

  localparam logic [1:0] RS_DATA   = 2'b00;
  localparam logic [1:0] RS_STATUS = 2'b01;
  localparam logic [1:0] RS_CTRL   = 2'b10;

  // cable-absent images
  localparam logic [DW-1:0] STAT_IDLE = 8'h48;
  localparam logic [DW-1:0] CTRL_IDLE = 8'h04;

  // pins carrying drive 0 only; blocked in mode 1
  localparam logic [DW-1:0] PD_DRV0 = 8'h40;
  localparam logic [CW-1:0] CT_DRV0 = 4'b0001;
  // control pins used by the floppy path
  localparam logic [CW-1:0] CT_USED = 4'b0011;

  typedef struct packed {
    logic [1:0] mtr;
    logic [1:0] ds;
    logic       step;
    logic       dir;
    logic       wgate;
    logic       hdsel;
    logic       densel;
    logic       wdata;
  } fdc_out_t;

  function automatic logic is_floppy(pmode_e m);
    return (m == PM_ONE) || (m == PM_TWO);
  endfunction
endpackage

// File: rtl/ppfd_cfg_regs.sv
module ppfd_cfg_regs
  import ppfd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic [MW-1:0] mode_wdata_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] data_wdata_i,
  output pmode_e        mode_o,
  output logic [DW-1:0] echo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= PM_NORMAL;
      echo_o <= '0;
    end else begin
      if (mode_wr_i) mode_o <= pmode_e'(mode_wdata_i);
      if (data_wr_i) echo_o <= data_wdata_i;
    end
  end

  assert_mode_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (mode_o == $past(mode_wdata_i)));

  assert_echo_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> (echo_o == $past(data_wdata_i)));

  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_wr_i |=> $stable(mode_o));
endmodule

// File: rtl/ppfd_pin_route.sv
module ppfd_pin_route
  import ppfd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pmode_e        mode_i,
  input  fdc_out_t      fdc_i,
  input  logic [1:0]    drv_sel_i,
  input  logic [DW-1:0] pp_pd_i,
  input  logic          pp_pd_oe_i,
  input  logic [CW-1:0] pp_ctl_i,
  input  logic          pp_ctl_oe_i,
  output logic [DW-1:0] pd_o,
  output logic [DW-1:0] pd_oe_o,
  output logic [CW-1:0] ctl_o,
  output logic [CW-1:0] ctl_oe_o
);
  logic          flop_on;
  logic          sel_ok;
  logic          two_drv;
  logic [DW-1:0] fd_pd;
  logic [CW-1:0] fd_ct;

  assign flop_on = is_floppy(mode_i);
  assign two_drv = (mode_i == PM_TWO);
  // drive select must point at a routed drive
  assign sel_ok  = (mode_i == PM_ONE && drv_sel_i == 2'd1) ||
                   (mode_i == PM_TWO && drv_sel_i <= 2'd1);

  assign fd_pd = {fdc_i.ds[1], fdc_i.ds[0], fdc_i.step, fdc_i.dir,
                  fdc_i.wgate, fdc_i.hdsel, fdc_i.densel, fdc_i.wdata};
  assign fd_ct = {{(CW-2){1'b0}}, fdc_i.mtr};

  for (genvar i = 0; i < DW; i++) begin : g_pd
    always_comb begin
      if (flop_on) begin
        pd_o[i]    = fd_pd[i];
        pd_oe_o[i] = sel_ok && (two_drv || !PD_DRV0[i]);
      end else begin
        pd_o[i]    = pp_pd_i[i];
        pd_oe_o[i] = pp_pd_oe_i;
      end
    end
  end

  for (genvar j = 0; j < CW; j++) begin : g_ct
    always_comb begin
      if (flop_on) begin
        ctl_o[j]    = fd_ct[j];
        ctl_oe_o[j] = sel_ok && CT_USED[j] && (two_drv || !CT_DRV0[j]);
      end else begin
        ctl_o[j]    = pp_ctl_i[j];
        ctl_oe_o[j] = pp_ctl_oe_i;
      end
    end
  end

  assert_drv0_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == PM_ONE) |-> (!pd_oe_o[6] && !ctl_oe_o[0]));

  assert_float_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flop_on && drv_sel_i[1]) |-> (pd_oe_o == '0 && ctl_oe_o == '0));

  assert_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flop_on |-> (pd_o == pp_pd_i && ctl_o == pp_ctl_i));

  assert_step_pin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flop_on |-> (pd_o[5] == fdc_i.step && ctl_o[1] == fdc_i.mtr[1]));
endmodule

// File: rtl/ppfd_read_ovr.sv
module ppfd_read_ovr
  import ppfd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pmode_e        mode_i,
  input  logic [1:0]    rd_sel_i,
  input  logic [DW-1:0] echo_i,
  input  logic [DW-1:0] pp_rd_data_i,
  output logic [DW-1:0] rd_data_o
);
  logic flop_on;
  assign flop_on = is_floppy(mode_i);

  always_comb begin
    rd_data_o = pp_rd_data_i;
    if (flop_on) begin
      unique case (rd_sel_i)
        RS_DATA:   rd_data_o = echo_i;
        RS_STATUS: rd_data_o = STAT_IDLE;
        RS_CTRL:   rd_data_o = CTRL_IDLE;
        default:   rd_data_o = pp_rd_data_i;
      endcase
    end
  end

  assert_stat_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flop_on && rd_sel_i == RS_STATUS) |-> (rd_data_o[7] == 1'b0 && rd_data_o[6] == 1'b1));

  assert_ctrl_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flop_on && rd_sel_i == RS_CTRL) |-> (rd_data_o[2] == 1'b1 && rd_data_o[0] == 1'b0));

  assert_read_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flop_on || rd_sel_i == 2'b11) |-> (rd_data_o == pp_rd_data_i));
endmodule

// File: rtl/ppfd_pin_mux.sv
module ppfd_pin_mux
  import ppfd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic [1:0]    mode_wdata_i,
  input  logic          data_wr_i,
  input  logic [7:0]    data_wdata_i,
  input  logic [1:0]    rd_sel_i,
  input  logic [7:0]    pp_rd_data_i,
  output logic [7:0]    rd_data_o,
  input  logic [7:0]    pp_pd_i,
  input  logic          pp_pd_oe_i,
  input  logic [3:0]    pp_ctl_i,
  input  logic          pp_ctl_oe_i,
  input  logic          fdc_wdata_i,
  input  logic          fdc_densel_i,
  input  logic          fdc_hdsel_i,
  input  logic          fdc_wgate_i,
  input  logic          fdc_dir_i,
  input  logic          fdc_step_i,
  input  logic [1:0]    fdc_ds_i,
  input  logic [1:0]    fdc_mtr_i,
  input  logic [1:0]    drv_sel_i,
  output logic [7:0]    pd_o,
  output logic [7:0]    pd_oe_o,
  output logic [3:0]    ctl_o,
  output logic [3:0]    ctl_oe_o
);
  pmode_e        mode_q;
  logic [DW-1:0] echo_q;
  fdc_out_t      fdc;

  assign fdc = '{mtr: fdc_mtr_i, ds: fdc_ds_i, step: fdc_step_i, dir: fdc_dir_i,
                 wgate: fdc_wgate_i, hdsel: fdc_hdsel_i, densel: fdc_densel_i,
                 wdata: fdc_wdata_i};

  ppfd_cfg_regs u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_wr_i    (mode_wr_i),
    .mode_wdata_i (mode_wdata_i),
    .data_wr_i    (data_wr_i),
    .data_wdata_i (data_wdata_i),
    .mode_o       (mode_q),
    .echo_o       (echo_q)
  );

  ppfd_pin_route u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .fdc_i       (fdc),
    .drv_sel_i   (drv_sel_i),
    .pp_pd_i     (pp_pd_i),
    .pp_pd_oe_i  (pp_pd_oe_i),
    .pp_ctl_i    (pp_ctl_i),
    .pp_ctl_oe_i (pp_ctl_oe_i),
    .pd_o        (pd_o),
    .pd_oe_o     (pd_oe_o),
    .ctl_o       (ctl_o),
    .ctl_oe_o    (ctl_oe_o)
  );

  ppfd_read_ovr u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_q),
    .rd_sel_i     (rd_sel_i),
    .echo_i       (echo_q),
    .pp_rd_data_i (pp_rd_data_i),
    .rd_data_o    (rd_data_o)
  );

  // R11: no parallel engine input reaches the pins in floppy mode
  assert_pp_blocked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_floppy(mode_q) && $stable(fdc) && $stable(drv_sel_i) && $stable(mode_q))
      |-> ($stable(pd_o) && $stable(pd_oe_o) && $stable(ctl_o) && $stable(ctl_oe_o)));
endmodule

// File: tb/ppfd_pin_mux_test.sv
module ppfd_pin_mux_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       mode_wr = 0, data_wr = 0, pp_pd_oe = 0, pp_ctl_oe = 0;
  logic [1:0] mode_wd = 0, rd_sel = 0, fds = 0, fmtr = 0, drv = 0;
  logic [7:0] data_wd = 0, pp_rd = 0, pp_pd = 0;
  logic [3:0] pp_ctl = 0;
  logic       fwd = 0, fden = 0, fhd = 0, fwg = 0, fdir = 0, fstp = 0;
  logic [7:0] rd_data, pd, pd_oe;
  logic [3:0] ctl, ctl_oe;

  ppfd_pin_mux uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_wdata_i(mode_wd),
    .data_wr_i(data_wr), .data_wdata_i(data_wd), .rd_sel_i(rd_sel),
    .pp_rd_data_i(pp_rd), .rd_data_o(rd_data), .pp_pd_i(pp_pd), .pp_pd_oe_i(pp_pd_oe),
    .pp_ctl_i(pp_ctl), .pp_ctl_oe_i(pp_ctl_oe), .fdc_wdata_i(fwd), .fdc_densel_i(fden),
    .fdc_hdsel_i(fhd), .fdc_wgate_i(fwg), .fdc_dir_i(fdir), .fdc_step_i(fstp),
    .fdc_ds_i(fds), .fdc_mtr_i(fmtr), .drv_sel_i(drv), .pd_o(pd), .pd_oe_o(pd_oe),
    .ctl_o(ctl), .ctl_oe_o(ctl_oe));

  int total = 0, bad = 0, cycles = 0;
  int m_mode = 0;
  int m_echo = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_echo <= 0;
    end else begin
      if (mode_wr) m_mode <= int'(mode_wd);
      if (data_wr) m_echo <= int'(data_wd);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit fl;
      int e_pd, e_ct, e_pdoe, e_ctoe, e_rd;
      string t_oe, t_rd;
      fl = (m_mode == 1 || m_mode == 2);
      if (!fl) begin
        e_pd = pp_pd; e_ct = pp_ctl;
        e_pdoe = pp_pd_oe ? 8'hFF : 0; e_ctoe = pp_ctl_oe ? 4'hF : 0;
        e_rd = pp_rd; t_oe = (m_mode == 3) ? "R2 R3" : "R3"; t_rd = "R4";
      end else begin
        e_pd = {fds[1], fds[0], fstp, fdir, fwg, fhd, fden, fwd};
        e_ct = {2'b00, fmtr};
        if (m_mode == 1) begin
          t_oe = "R9 R11";
          e_pdoe = (drv == 1) ? 8'hBF : 0; e_ctoe = (drv == 1) ? 4'b0010 : 0;
        end else begin
          t_oe = "R10 R11";
          e_pdoe = (drv <= 1) ? 8'hFF : 0; e_ctoe = (drv <= 1) ? 4'b0011 : 0;
        end
        case (rd_sel)
          2'b00: begin e_rd = m_echo; t_rd = "R5 R11"; end
          2'b01: begin e_rd = 8'h48;  t_rd = "R7 R11"; end
          2'b10: begin e_rd = 8'h04;  t_rd = "R6 R11"; end
          default: begin e_rd = pp_rd; t_rd = "R4"; end
        endcase
      end
      check(fl ? "R8 R11" : "R3", pd, e_pd);
      check(fl ? "R8 R11" : "R3", ctl, e_ct);
      check(t_oe, pd_oe, e_pdoe);
      check(t_oe, ctl_oe, e_ctoe);
      check(t_rd, rd_data, e_rd);
    end
  end

  task automatic step_rand(bit allow_dw);
    @(posedge clk); #1;
    mode_wr = 0;
    data_wr = allow_dw ? 1'($urandom_range(0, 1)) : 1'b0;
    data_wd = 8'($urandom); rd_sel = 2'($urandom); drv = 2'($urandom);
    pp_rd = 8'($urandom); pp_pd = 8'($urandom); pp_ctl = 4'($urandom);
    pp_pd_oe = 1'($urandom); pp_ctl_oe = 1'($urandom);
    {fwd, fden, fhd, fwg, fdir, fstp} = 6'($urandom);
    fds = 2'($urandom); fmtr = 2'($urandom);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(posedge clk); #1;
    mode_wr = 1; mode_wd = m; data_wr = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state is normal passthrough
    pp_pd = 8'hA5; pp_pd_oe = 1; rd_sel = 2'b00; pp_rd = 8'h3C;
    @(negedge clk);
    check("R1", pd, 8'hA5);
    check("R1", rd_data, 8'h3C);
    // R1: echo byte is 0 after reset, visible once in floppy mode
    set_mode(2'b01);
    @(posedge clk); #1; mode_wr = 0; rd_sel = 2'b00;
    @(negedge clk);
    check("R1", rd_data, 8'h00);
    // R2: mode takes effect one edge after the write
    @(posedge clk); #1; mode_wr = 1; mode_wd = 2'b00; rd_sel = 2'b01; pp_rd = 8'h11;
    @(negedge clk);
    check("R2", rd_data, 8'h48);
    @(posedge clk); #1; mode_wr = 0;
    @(negedge clk);
    check("R2", rd_data, 8'h11);
    for (int r = 0; r < 3; r++) begin
      for (int m = 0; m < 4; m++) begin
        set_mode(2'(m));
        for (int k = 0; k < 150; k++) step_rand(k % 5 != 4);
      end
    end
    // mode switch with data write in flight (R5)
    set_mode(2'b10);
    @(posedge clk); #1; mode_wr = 0; data_wr = 1; data_wd = 8'h9E; rd_sel = 2'b00;
    @(posedge clk); #1; data_wr = 0;
    @(negedge clk);
    check("R5", rd_data, 8'h9E);
    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule